// File: doc/BRIEF.md
# Priority interrupt acceptance unit

This block decides, every clock cycle, whether a small processor core should take a maskable interrupt and which source it should take. Each source owns a latched request bit and a 3-bit priority level. The request bit is set by a rising edge on the source line. The unit combines the request bits and levels with the core's interrupt enable flag and its 3-bit processor priority level. From the requests that qualify it picks one winner, then emits a one-cycle acknowledge strobe together with the vector number and the vector fetch address.

In the same clock edge that raises the strobe, the winning request bit is cleared and the processor priority level is loaded with the level of the accepted interrupt. The enable flag and the processor priority level are held inside the unit and software writes them through dedicated write strobes. A separate software-interrupt request path covers vector numbers 58 to 63. These requests ignore the enable flag and the priority level. Each source's vector number is fixed by a parameter. Vector table entries are 4 bytes wide and are placed relative to a 32-bit table base.

Top module: `irq_accept_unit`

## Requirements
- R1: A maskable source is acknowledged only when the enable flag is 1, its request bit is 1 and its level is strictly greater than the processor priority level. With the flag at 0, a pending request stays pending and is not taken.
- R2: With processor priority level n, only levels n+1 to 7 are taken. A source at level 0 is never taken. At processor level 7 no maskable source is taken.
- R3: After reset the enable flag is 0, the processor level is 0, all request bits are 0, all source levels are 0 and the acknowledge strobe is low.
- R4: Writing the enable flag, the processor level, a source level or a request clear changes only that storage. The other three are left as they were.
- R5: With an acknowledge, vec_o carries the vector number k and vaddr_o equals table base + 4k, truncated to 32 bits. For example, k = 57 gives base + 0xE4, and base 0xFFFFFFF0 with k = 61 gives 0x000000E4.
- R6: A software request with swi_sel_i = s, for s from 0 to 5, is acknowledged as vector 58+s whatever the enable flag and the processor level are. It wins over any maskable request in the same cycle and leaves the processor level unchanged. The codes s = 6 and s = 7 are ignored.
- R7: Among qualifying maskable requests, the highest level wins. On equal levels the lower vector number wins.
- R8: ack_o is high for one cycle. In that cycle pend_o already shows the winning bit cleared and ipl_o already shows the accepted level.
- R9: A request bit is set by a 0-to-1 transition of its source line. A line held high does not set the bit again. The bit stays set until it is acknowledged or cleared through pend_clr_i.
- R10: No acknowledge is issued in the cycle directly after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Source request lines, rising edge latches |
| pend_clr_i | input | N_SRC | Software clear mask for request bits |
| lvl_we_i | input | 1 | Source level write strobe |
| lvl_idx_i | input | IDX_W | Source selected for level write |
| lvl_wdata_i | input | 3 | New source level |
| ien_we_i | input | 1 | Enable flag write strobe |
| ien_wdata_i | input | 1 | New enable flag value |
| ipl_we_i | input | 1 | Processor level write strobe |
| ipl_wdata_i | input | 3 | New processor level |
| tbase_i | input | 32 | Vector table base address |
| swi_req_i | input | 1 | Software interrupt request, held until acknowledged |
| swi_sel_i | input | 3 | Software interrupt select, vector 58+sel |
| ack_o | output | 1 | Acknowledge strobe |
| vec_o | output | 6 | Accepted vector number |
| vaddr_o | output | 32 | Vector fetch address |
| ien_o | output | 1 | Interrupt enable flag |
| ipl_o | output | 3 | Processor priority level |
| pend_o | output | N_SRC | Request bits |

## Verification
Some rules hold on every cycle and are checked continuously by the assertions. The strobe never lasts two cycles. A maskable acknowledge always comes with a prior enable flag of 1 and a raised processor level. The fetch address always matches the base plus four times the vector. Every maskable acknowledge removes a request bit. The reset state is also checked this way. Other behaviours depend on the history of writes and edges, and only the directed scenarios can show them. These are the choice of winner on level and on tie, level 0 and level 7 blocking, edge rather than level latching, software request precedence and the ignored select codes, and the independence of the four kinds of storage.

// File: rtl/irq_accept_pkg.sv
// Package: shared types and constants for the interrupt acceptance unit.
// Assumes 3-bit priority levels and 6-bit vector numbers throughout.
package irq_accept_pkg;
    typedef logic [2:0] lvl_t;
    typedef logic [5:0] vec_t;
    localparam int unsigned SWI_FIRST = 58;
    localparam int unsigned SWI_COUNT = 6;
    localparam lvl_t        LVL_MAX   = 3'd7;
endpackage

// File: rtl/irq_req_bank.sv
// Request bank: per-source edge detector, request bit and level field.
// Assumes clear and acknowledge masks are single-cycle; a new edge wins.
module irq_req_bank
    import irq_accept_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      src_i,
    input  logic [N_SRC-1:0]      clr_i,
    input  logic                  lvl_we_i,
    input  logic [IDX_W-1:0]      lvl_idx_i,
    input  lvl_t                  lvl_wdata_i,
    output logic [N_SRC-1:0]      pend_o,
    output lvl_t [N_SRC-1:0]      lvl_o
);
    logic [N_SRC-1:0] src_q;

    // Remember last source line values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        // Request bit: set on rising edge, cleared by ack or software.
        always_ff @(posedge clk) begin
            if (!rst_n)                     pend_o[g] <= 1'b0;
            else if (src_i[g] && !src_q[g]) pend_o[g] <= 1'b1;
            else if (clr_i[g])              pend_o[g] <= 1'b0;
        end

        // Level field: written only when this source is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_o[g] <= '0;
            else if (lvl_we_i && (lvl_idx_i == IDX_W'(g)))
                lvl_o[g] <= lvl_wdata_i;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Arbiter: filters requests by enable flag and level, picks the winner.
// Assumes vector numbers in VEC_TABLE are below the software range.
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter int unsigned N_SRC     = 8,
    parameter int unsigned VEC_W     = 6,
    parameter logic [N_SRC*VEC_W-1:0] VEC_TABLE = '0,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]  pend_i,
    input  lvl_t [N_SRC-1:0]  lvl_i,
    input  logic              ien_i,
    input  lvl_t              ipl_i,
    output logic              win_vld_o,
    output logic [IDX_W-1:0]  win_idx_o,
    output lvl_t              win_lvl_o,
    output logic [VEC_W-1:0]  win_vec_o
);
    logic [N_SRC-1:0] elig;

    // Qualify each source against enable flag and processor level.
    always_comb begin
        for (int i = 0; i < N_SRC; i++)
            elig[i] = pend_i[i] && ien_i && (lvl_i[i] > ipl_i);
    end

    // Highest level wins; equal levels go to the lower vector number.
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        win_vec_o = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!win_vld_o || (lvl_i[i] > win_lvl_o) ||
                ((lvl_i[i] == win_lvl_o) &&
                 (VEC_TABLE[i*VEC_W +: VEC_W] < win_vec_o)))) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(i);
                win_lvl_o = lvl_i[i];
                win_vec_o = VEC_TABLE[i*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/irq_vec_addr.sv
// Vector address: table base plus four bytes per vector number.
// Assumes wrap-around at the address width, no carry out.
module irq_vec_addr #(
    parameter int unsigned VEC_W  = 6,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned PAD_W = ADDR_W - VEC_W - 2;

    // Scale the vector number to a byte offset and add it to the base.
    always_comb addr_o = base_i + {{PAD_W{1'b0}}, vec_i, 2'b00};
endmodule

// File: rtl/irq_accept_unit.sv
// Top: holds enable flag and processor level, registers the acknowledge.
// Assumes swi_req_i is held until ack_o shows the software vector.
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned VEC_W  = 6,
    parameter int unsigned ADDR_W = 32,
    parameter logic [N_SRC*VEC_W-1:0] VEC_TABLE =
        {6'd57, 6'd56, 6'd55, 6'd54, 6'd53, 6'd52, 6'd51, 6'd50},
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [N_SRC-1:0]  pend_clr_i,
    input  logic              lvl_we_i,
    input  logic [IDX_W-1:0]  lvl_idx_i,
    input  logic [2:0]        lvl_wdata_i,
    input  logic              ien_we_i,
    input  logic              ien_wdata_i,
    input  logic              ipl_we_i,
    input  logic [2:0]        ipl_wdata_i,
    input  logic [ADDR_W-1:0] tbase_i,
    input  logic              swi_req_i,
    input  logic [2:0]        swi_sel_i,
    output logic              ack_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [ADDR_W-1:0] vaddr_o,
    output logic              ien_o,
    output logic [2:0]        ipl_o,
    output logic [N_SRC-1:0]  pend_o
);
    lvl_t [N_SRC-1:0] lvl;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic [VEC_W-1:0] win_vec;
    logic             take_swi, take_irq;
    logic [VEC_W-1:0] sel_vec;
    logic [ADDR_W-1:0] sel_addr;
    logic [N_SRC-1:0] ack_clr;

    irq_req_bank #(.N_SRC(N_SRC)) bank_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(pend_clr_i | ack_clr),
        .lvl_we_i(lvl_we_i), .lvl_idx_i(lvl_idx_i), .lvl_wdata_i(lvl_wdata_i),
        .pend_o(pend_o), .lvl_o(lvl)
    );

    irq_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_TABLE(VEC_TABLE)) arb_i (
        .pend_i(pend_o), .lvl_i(lvl), .ien_i(ien_o), .ipl_i(ipl_o),
        .win_vld_o(win_vld), .win_idx_o(win_idx), .win_lvl_o(win_lvl),
        .win_vec_o(win_vec)
    );

    irq_vec_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) addr_i (
        .base_i(tbase_i), .vec_i(sel_vec), .addr_o(sel_addr)
    );

    // Decide what is taken this cycle; nothing right after an acknowledge.
    always_comb begin
        take_swi = swi_req_i && (swi_sel_i < 3'(SWI_COUNT)) && !ack_o;
        take_irq = !take_swi && win_vld && !ack_o;
        sel_vec  = take_swi ? VEC_W'(SWI_FIRST + swi_sel_i) : win_vec;
        ack_clr  = '0;
        if (take_irq) ack_clr[win_idx] = 1'b1;
    end

    // Acknowledge strobe with its vector and fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            vec_o   <= '0;
            vaddr_o <= '0;
        end else begin
            ack_o <= take_swi || take_irq;
            if (take_swi || take_irq) begin
                vec_o   <= sel_vec;
                vaddr_o <= sel_addr;
            end
        end
    end

    // Processor level: loaded on maskable accept, else by software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ipl_o <= '0;
        else if (take_irq) ipl_o <= win_lvl;
        else if (ipl_we_i) ipl_o <= ipl_wdata_i;
    end

    // Enable flag: changed only by its own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_o <= 1'b0;
        else if (ien_we_i) ien_o <= ien_wdata_i;
    end
endmodule

// File: rtl/irq_accept_chk.sv
// Checker: cycle-by-cycle properties of the acceptance unit's ports.
// Assumes table vectors below 58, so vec_o < 58 marks a maskable accept.
module irq_accept_chk
    import irq_accept_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned VEC_W  = 6,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic [ADDR_W-1:0] vaddr_o,
    input logic [ADDR_W-1:0] tbase_i,
    input logic              ien_o,
    input logic [2:0]        ipl_o,
    input logic [N_SRC-1:0]  pend_o
);
    localparam int unsigned PAD_W = ADDR_W - VEC_W - 2;
    logic maskable;
    always_comb maskable = ack_o && (vec_o < VEC_W'(SWI_FIRST));

    // R10
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R1
    ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> $past(ien_o));

    // R2
    level_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> (ipl_o > $past(ipl_o)));

    // R5
    vaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (vaddr_o == $past(tbase_i) + {{PAD_W{1'b0}}, vec_o, 2'b00}));

    // R8
    winner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> ($countones($past(pend_o) & ~pend_o) >= 1));

    // R3
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!ien_o && (ipl_o == 3'd0) && !ack_o && (pend_o == '0)));
endmodule

bind irq_accept_unit irq_accept_chk #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ack_o(ack_o), .vec_o(vec_o),
    .vaddr_o(vaddr_o), .tbase_i(tbase_i), .ien_o(ien_o),
    .ipl_o(ipl_o), .pend_o(pend_o)
);

// File: tb/irq_accept_unit_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_accept_unit_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_i = '0, pend_clr_i = '0;
    logic        lvl_we_i = 1'b0;
    logic [2:0]  lvl_idx_i = '0, lvl_wdata_i = '0;
    logic        ien_we_i = 1'b0, ien_wdata_i = 1'b0;
    logic        ipl_we_i = 1'b0;
    logic [2:0]  ipl_wdata_i = '0;
    logic [31:0] tbase_i = 32'h0000_1000;
    logic        swi_req_i = 1'b0;
    logic [2:0]  swi_sel_i = '0;
    logic        ack_o, ien_o;
    logic [5:0]  vec_o;
    logic [31:0] vaddr_o;
    logic [2:0]  ipl_o;
    logic [N-1:0] pend_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    irq_accept_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .pend_clr_i(pend_clr_i),
        .lvl_we_i(lvl_we_i), .lvl_idx_i(lvl_idx_i), .lvl_wdata_i(lvl_wdata_i),
        .ien_we_i(ien_we_i), .ien_wdata_i(ien_wdata_i),
        .ipl_we_i(ipl_we_i), .ipl_wdata_i(ipl_wdata_i), .tbase_i(tbase_i),
        .swi_req_i(swi_req_i), .swi_sel_i(swi_sel_i),
        .ack_o(ack_o), .vec_o(vec_o), .vaddr_o(vaddr_o),
        .ien_o(ien_o), .ipl_o(ipl_o), .pend_o(pend_o)
    );

    always #4 clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ien(input logic v);
        ien_we_i = 1'b1; ien_wdata_i = v; tick(); ien_we_i = 1'b0;
    endtask

    task automatic set_ipl(input logic [2:0] v);
        ipl_we_i = 1'b1; ipl_wdata_i = v; tick(); ipl_we_i = 1'b0;
    endtask

    task automatic set_lvl(input int idx, input logic [2:0] v);
        lvl_we_i = 1'b1; lvl_idx_i = 3'(idx); lvl_wdata_i = v; tick();
        lvl_we_i = 1'b0;
    endtask

    task automatic clr_all();
        pend_clr_i = '1; tick(); pend_clr_i = '0;
    endtask

    // Returns at the first negedge where ack_o is high, or after maxc cycles.
    task automatic wait_ack(input int maxc, output bit got, output logic [5:0] v,
                            output logic [31:0] a);
        got = 1'b0; v = '0; a = '0;
        for (int i = 0; i < maxc; i++) begin
            tick();
            if (ack_o) begin
                got = 1'b1; v = vec_o; a = vaddr_o;
                break;
            end
        end
    endtask

    task automatic t_reset();
        tick(3); rst_n = 1'b1; tick();
        chk(ien_o == 1'b0, "R3 ien", 32'(ien_o), 0);
        chk(ipl_o == 3'd0, "R3 ipl", 32'(ipl_o), 0);
        chk(pend_o == '0, "R3 pend", 32'(pend_o), 0);
        chk(ack_o == 1'b0, "R3 ack", 32'(ack_o), 0);
    endtask

    task automatic t_gate_and_edge();
        bit g; logic [5:0] v; logic [31:0] a;
        set_lvl(0, 3'd3);
        src_i[0] = 1'b1;
        wait_ack(6, g, v, a);
        chk(!g, "R1 taken with flag clear", 32'(g), 0);
        chk(pend_o[0], "R9 edge latched", 32'(pend_o[0]), 1);
        set_ien(1'b1);
        wait_ack(6, g, v, a);
        chk(g && v == 6'd50, "R1 accept src0", 32'(v), 50);
        chk(ipl_o == 3'd3, "R8 level loaded", 32'(ipl_o), 3);
        chk(pend_o[0] == 1'b0, "R8 winner cleared", 32'(pend_o[0]), 0);
        tick();
        chk(ack_o == 1'b0, "R8 single pulse", 32'(ack_o), 0);
        set_ipl(3'd0);
        tick(4);
        chk(pend_o[0] == 1'b0, "R9 held line no reset", 32'(pend_o[0]), 0);
        src_i[0] = 1'b0;
        tick();
    endtask

    task automatic t_levels();
        bit g; logic [5:0] v; logic [31:0] a;
        set_ipl(3'd4); set_lvl(1, 3'd4);
        src_i[1] = 1'b1; tick(); src_i[1] = 1'b0;
        wait_ack(6, g, v, a);
        chk(!g, "R2 equal level blocked", 32'(g), 0);
        set_lvl(1, 3'd5);
        wait_ack(6, g, v, a);
        chk(g && v == 6'd51, "R2 level above taken", 32'(v), 51);
        chk(ipl_o == 3'd5, "R2 ipl now 5", 32'(ipl_o), 5);
        tick(); set_ipl(3'd0);
        src_i[2] = 1'b1; tick(); src_i[2] = 1'b0;
        wait_ack(6, g, v, a);
        chk(!g && pend_o[2], "R2 level 0 never", 32'(g), 0);
        clr_all();
        set_ipl(3'd7); set_lvl(3, 3'd7);
        src_i[3] = 1'b1; tick(); src_i[3] = 1'b0;
        wait_ack(6, g, v, a);
        chk(!g, "R2 ipl 7 blocks", 32'(g), 0);
        clr_all();
        chk(pend_o == '0, "R9 software clear", 32'(pend_o), 0);
    endtask

    task automatic t_priority();
        bit g; logic [5:0] v; logic [31:0] a;
        set_ipl(3'd0);
        set_lvl(4, 3'd2); set_lvl(5, 3'd6); set_lvl(6, 3'd6);
        src_i[6:4] = 3'b111; tick(); src_i[6:4] = '0;
        wait_ack(6, g, v, a);
        chk(g && v == 6'd55, "R7 highest then lowest vector", 32'(v), 55);
        chk(ipl_o == 3'd6, "R7 accepted level", 32'(ipl_o), 6);
        wait_ack(4, g, v, a);
        chk(!g, "R2 remaining not above", 32'(g), 0);
        set_ipl(3'd0);
        wait_ack(6, g, v, a);
        chk(g && v == 6'd56, "R7 next winner", 32'(v), 56);
        clr_all();
        set_ipl(3'd0); set_lvl(0, 3'd5); set_lvl(1, 3'd5);
        src_i[1:0] = 2'b11; tick(); src_i[1:0] = '0;
        wait_ack(6, g, v, a);
        chk(g && v == 6'd50, "R7 tie lower vector", 32'(v), 50);
        clr_all();
        set_ipl(3'd0);
    endtask

    task automatic t_swi();
        bit g; logic [5:0] v; logic [31:0] a;
        set_ien(1'b0); set_ipl(3'd7);
        swi_sel_i = 3'd5; swi_req_i = 1'b1;
        wait_ack(6, g, v, a); swi_req_i = 1'b0;
        chk(g && v == 6'd63, "R6 swi ignores gating", 32'(v), 63);
        chk(a == 32'h0000_10FC, "R5 swi address", a, 32'h0000_10FC);
        chk(ipl_o == 3'd7, "R6 ipl unchanged", 32'(ipl_o), 7);
        tick();
        swi_sel_i = 3'd6; swi_req_i = 1'b1;
        wait_ack(5, g, v, a); swi_req_i = 1'b0;
        chk(!g, "R6 code 6 ignored", 32'(g), 0);
        set_ien(1'b1); set_ipl(3'd0); set_lvl(7, 3'd1);
        src_i[7] = 1'b1; swi_sel_i = 3'd0; swi_req_i = 1'b1;
        tick();
        chk(ack_o && vec_o == 6'd58, "R6 swi precedence", 32'(vec_o), 58);
        swi_req_i = 1'b0; src_i[7] = 1'b0;
        tick();
        chk(!ack_o, "R10 gap after swi", 32'(ack_o), 0);
        tick();
        chk(ack_o && vec_o == 6'd57, "R5 vector 57", 32'(vec_o), 57);
        chk(vaddr_o == 32'h0000_10E4, "R5 offset E4", vaddr_o, 32'h0000_10E4);
        tick(); set_ipl(3'd0);
    endtask

    task automatic t_gap_and_wrap();
        logic [3:0] seen;
        tbase_i = 32'hFFFF_FFF0;
        swi_sel_i = 3'd3; swi_req_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(); seen[i] = ack_o;
        end
        swi_req_i = 1'b0;
        chk(seen == 4'b0101, "R10 alternating acks", 32'(seen), 32'h5);
        chk(vec_o == 6'd61 && vaddr_o == 32'h0000_00E4, "R5 wrap",
            vaddr_o, 32'h0000_00E4);
        tbase_i = 32'h0000_1000;
        tick(2);
    endtask

    task automatic t_independence();
        set_ien(1'b1); set_ipl(3'd7); set_lvl(2, 3'd0);
        src_i[2] = 1'b1; tick(); src_i[2] = 1'b0; tick();
        set_ipl(3'd2);
        chk(ien_o == 1'b1 && pend_o[2], "R4 ipl write isolated",
            {ien_o, pend_o}, {1'b1, 8'h04});
        set_ien(1'b0);
        chk(ipl_o == 3'd2 && pend_o[2], "R4 flag write isolated",
            {ipl_o, pend_o}, {3'd2, 8'h04});
        set_lvl(2, 3'd6);
        chk(ipl_o == 3'd2 && !ien_o && pend_o == 8'h04, "R4 level write isolated",
            {ien_o, ipl_o, pend_o}, {1'b0, 3'd2, 8'h04});
        clr_all();
        chk(ipl_o == 3'd2 && !ien_o && pend_o == '0, "R4 clear isolated",
            {ien_o, ipl_o, pend_o}, {1'b0, 3'd2, 8'h00});
    endtask

    initial begin
        t_reset();
        t_gate_and_edge();
        t_levels();
        t_priority();
        t_swi();
        t_gap_and_wrap();
        t_independence();
        report();
    end
endmodule